// File: doc/BRIEF.md
# Control Endpoint SETUP Capture Unit

This unit runs the SETUP stage of endpoint 0 in a USB device controller without firmware help. A packet decoder upstream supplies a token strobe with its PID class, address and endpoint number. For the data packet that follows it supplies a start strobe with a DATA0 flag, a stream of byte strobes, and an end strobe carrying the CRC verdict. When the device function is enabled and a SETUP token names endpoint 0 at this node's own address, the unit stages the next data packet. The packet is accepted only if it is DATA0, holds exactly eight bytes and passes CRC. On acceptance the eight bytes are published to firmware together, an ACK handshake request goes out, and a sticky SETUP-received flag is raised.

On that same edge both directions of endpoint 0 are put into a known state for the next stage. The forced-NAK bit is set and the forced-STALL bit is cleared, and the data toggle is set. Firmware later clears forced-NAK for the direction it is ready to serve. Any fault in the transaction leaves the unit completely silent: no handshake, no status, and no change to the published bytes.

Top module: `ep0_setup_capture`

## Requirements
- R1: A transaction is taken up only when `func_en` is high and a token strobe has `tok_is_setup`=1, `tok_addr`=`own_addr` and `tok_endp`=0. Any other token produces no ACK, no status and no change to the bytes or control bits.
- R2: Byte k of an accepted packet (k = 0..7, in arrival order) appears at `setup_data[8k+7:8k]`. All eight bytes change together, one cycle after the `dat_end` cycle.
- R3: For an accepted packet, `hs_ack` is high for exactly one cycle, the cycle after `dat_end`. `setup_rcvd` is set on that same edge and stays high until a `fw_setup_clr` cycle in which no new packet is accepted.
- R4: A data packet is rejected if `dat_pid_data0`=0 at `dat_start`, if `dat_crc_ok`=0 at `dat_end`, or if it holds any byte count other than eight. A rejected packet gives no `hs_ack`, leaves `setup_rcvd` as it was and leaves `setup_data` unchanged.
- R5: On acceptance, both directions of endpoint 0 get forced-NAK=1, forced-STALL=0 and toggle=1.
- R6: Outside acceptance, a cycle with `fw_ctl_we_in` or `fw_ctl_we_out` loads that direction from `fw_ctl_wdata`, where bit 2 is forced-NAK, bit 1 is forced-STALL and bit 0 is toggle. When a firmware write and an acceptance fall in the same cycle, the acceptance values win.
- R7: A SETUP packet is acknowledged even when forced-NAK or forced-STALL was already set on either direction.
- R8: A new token strobe during the data phase abandons the pending transaction and is judged afresh under R1. Dropping `func_en` also abandons it.
- R9: After reset, `hs_ack`=0, `setup_rcvd`=0, `setup_data`=0 and all six control bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_en | input | 1 | Device function enabled |
| own_addr | input | 7 | This node's bus address |
| tok_valid | input | 1 | Token received strobe |
| tok_is_setup | input | 1 | Token PID is SETUP |
| tok_addr | input | 7 | Token address field |
| tok_endp | input | 4 | Token endpoint field |
| dat_start | input | 1 | Data packet start strobe |
| dat_pid_data0 | input | 1 | Data packet PID is DATA0 (valid with dat_start) |
| dat_byte_valid | input | 1 | Payload byte strobe |
| dat_byte | input | 8 | Payload byte |
| dat_end | input | 1 | Data packet end strobe |
| dat_crc_ok | input | 1 | CRC verdict (valid with dat_end) |
| fw_ctl_we_in | input | 1 | Firmware write to IN-direction control bits |
| fw_ctl_we_out | input | 1 | Firmware write to OUT-direction control bits |
| fw_ctl_wdata | input | 3 | Control write value {nak, stall, toggle} |
| fw_setup_clr | input | 1 | Firmware clear of the SETUP-received flag |
| hs_ack | output | 1 | ACK handshake request pulse |
| setup_rcvd | output | 1 | Sticky SETUP-received status |
| setup_data | output | 64 | Captured request bytes, byte 0 in bits 7:0 |
| ep0_in_nak | output | 1 | IN forced-NAK |
| ep0_in_stall | output | 1 | IN forced-STALL |
| ep0_in_toggle | output | 1 | IN data toggle |
| ep0_out_nak | output | 1 | OUT forced-NAK |
| ep0_out_stall | output | 1 | OUT forced-STALL |
| ep0_out_toggle | output | 1 | OUT data toggle |

## Verification
Every cycle, the assertions check several local properties. The ACK is a single-cycle pulse that always follows a clean end strobe, and it always arrives together with the status flag and the post-SETUP control pattern. The published bytes never move without an ACK, and no ACK follows a cycle with the function disabled. What only the bench scenarios can show is the choice between accept and reject. This covers address and endpoint mismatches, short and long packets, DATA1, CRC faults, aborts by a fresh token, and the race between a firmware write and acceptance. The bench also confirms that the bytes land in arrival order.

// File: rtl/ep0_setup_pkg.sv
package ep0_setup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_DATA = 2'd1,
    ST_RECV      = 2'd2
  } cap_state_t;

  typedef struct packed {
    logic nak;
    logic stall;
    logic toggle;
  } ep_ctl_t;

  localparam ep_ctl_t CTL_AFTER_SETUP = '{nak: 1'b1, stall: 1'b0, toggle: 1'b1};
  localparam ep_ctl_t CTL_RESET       = '{nak: 1'b0, stall: 1'b0, toggle: 1'b0};

endpackage

// File: rtl/setup_seq_fsm.sv
module setup_seq_fsm
  import ep0_setup_pkg::*;
#(
  parameter int LEN    = 8,
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  localparam int CNT_W = $clog2(LEN + 2),
  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              func_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              tok_valid,
  input  logic              tok_is_setup,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_endp,
  input  logic              dat_start,
  input  logic              dat_pid_data0,
  input  logic              dat_byte_valid,
  input  logic              dat_end,
  input  logic              dat_crc_ok,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              commit
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LEN);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(LEN + 1);

  cap_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tok_hit;
  logic             in_recv;

  assign tok_hit = tok_valid && tok_is_setup && (tok_addr == own_addr) && (tok_endp == '0);
  // Payload handling only when no higher-priority event preempts it
  assign in_recv = (state_q == ST_RECV) && func_en && !tok_valid;

  assign commit = in_recv && dat_end && dat_crc_ok && (cnt_q == CNT_FULL);
  assign wr_en  = in_recv && !dat_end && dat_byte_valid && (cnt_q < CNT_FULL);
  assign wr_idx = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (!func_en) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (tok_valid) begin
      state_q <= tok_hit ? ST_WAIT_DATA : ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_WAIT_DATA: begin
          if (dat_start) begin
            state_q <= dat_pid_data0 ? ST_RECV : ST_IDLE;
            cnt_q   <= '0;
          end
        end
        ST_RECV: begin
          if (dat_end) begin
            state_q <= ST_IDLE;
          end else if (dat_byte_valid && (cnt_q != CNT_OVER)) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/setup_byte_buffer.sv
module setup_byte_buffer #(
  parameter int LEN    = 8,
  parameter int DW     = 8,
  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     din,
  input  logic              commit,
  output logic [LEN*DW-1:0] data_q
);

  // Staging store: written one byte at a time, no reset, RAM-style
  logic [DW-1:0] stage [LEN];

  always_ff @(posedge clk) begin
    if (wr_en) stage[wr_idx] <= din;
  end

  // Published copy: all lanes move together on commit only
  for (genvar i = 0; i < LEN; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)         data_q[i*DW +: DW] <= '0;
      else if (commit) data_q[i*DW +: DW] <= stage[i];
    end
  end

endmodule

// File: rtl/ep0_dir_ctl.sv
module ep0_dir_ctl
  import ep0_setup_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    setup_done,
  input  logic    fw_we,
  input  ep_ctl_t fw_wdata,
  output ep_ctl_t ctl_q
);

  always_ff @(posedge clk) begin
    if (rst)             ctl_q <= CTL_RESET;
    else if (setup_done) ctl_q <= CTL_AFTER_SETUP;
    else if (fw_we)      ctl_q <= fw_wdata;
  end

endmodule

// File: rtl/ep0_setup_capture.sv
module ep0_setup_capture
  import ep0_setup_pkg::*;
#(
  parameter int LEN    = 8,
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  localparam int DW    = 8,
  localparam int IDX_W = (LEN > 1) ? $clog2(LEN) : 1,
  localparam int NDIR  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              func_en,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              tok_valid,
  input  logic              tok_is_setup,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_endp,
  input  logic              dat_start,
  input  logic              dat_pid_data0,
  input  logic              dat_byte_valid,
  input  logic [DW-1:0]     dat_byte,
  input  logic              dat_end,
  input  logic              dat_crc_ok,
  input  logic              fw_ctl_we_in,
  input  logic              fw_ctl_we_out,
  input  logic [2:0]        fw_ctl_wdata,
  input  logic              fw_setup_clr,
  output logic              hs_ack,
  output logic              setup_rcvd,
  output logic [LEN*DW-1:0] setup_data,
  output logic              ep0_in_nak,
  output logic              ep0_in_stall,
  output logic              ep0_in_toggle,
  output logic              ep0_out_nak,
  output logic              ep0_out_stall,
  output logic              ep0_out_toggle
);

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             commit;

  setup_seq_fsm #(.LEN(LEN), .ADDR_W(ADDR_W), .EP_W(EP_W)) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .func_en        (func_en),
    .own_addr       (own_addr),
    .tok_valid      (tok_valid),
    .tok_is_setup   (tok_is_setup),
    .tok_addr       (tok_addr),
    .tok_endp       (tok_endp),
    .dat_start      (dat_start),
    .dat_pid_data0  (dat_pid_data0),
    .dat_byte_valid (dat_byte_valid),
    .dat_end        (dat_end),
    .dat_crc_ok     (dat_crc_ok),
    .wr_en          (wr_en),
    .wr_idx         (wr_idx),
    .commit         (commit)
  );

  setup_byte_buffer #(.LEN(LEN), .DW(DW)) u_buf (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .din    (dat_byte),
    .commit (commit),
    .data_q (setup_data)
  );

  // Direction 0 = IN, direction 1 = OUT
  logic [NDIR-1:0] fw_we;
  ep_ctl_t         ctl_q [NDIR];

  assign fw_we = {fw_ctl_we_out, fw_ctl_we_in};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    ep0_dir_ctl u_ctl (
      .clk        (clk),
      .rst        (rst),
      .setup_done (commit),
      .fw_we      (fw_we[d]),
      .fw_wdata   (ep_ctl_t'(fw_ctl_wdata)),
      .ctl_q      (ctl_q[d])
    );
  end

  assign ep0_in_nak     = ctl_q[0].nak;
  assign ep0_in_stall   = ctl_q[0].stall;
  assign ep0_in_toggle  = ctl_q[0].toggle;
  assign ep0_out_nak    = ctl_q[1].nak;
  assign ep0_out_stall  = ctl_q[1].stall;
  assign ep0_out_toggle = ctl_q[1].toggle;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_ack     <= 1'b0;
      setup_rcvd <= 1'b0;
    end else begin
      hs_ack <= commit;
      if (commit)            setup_rcvd <= 1'b1;
      else if (fw_setup_clr) setup_rcvd <= 1'b0;
    end
  end

endmodule

// File: rtl/ep0_setup_capture_chk.sv
module ep0_setup_capture_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         func_en,
  input logic         dat_end,
  input logic         dat_crc_ok,
  input logic         hs_ack,
  input logic         setup_rcvd,
  input logic [W-1:0] setup_data,
  input logic         ep0_in_nak,
  input logic         ep0_in_stall,
  input logic         ep0_in_toggle,
  input logic         ep0_out_nak,
  input logic         ep0_out_stall,
  input logic         ep0_out_toggle
);

  // R3
  ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    hs_ack |=> !hs_ack);

  // R3
  ack_with_status_chk: assert property (@(posedge clk) disable iff (rst)
    hs_ack |-> setup_rcvd);

  // R5
  ack_ctl_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    hs_ack |-> (ep0_in_nak && !ep0_in_stall && ep0_in_toggle &&
                ep0_out_nak && !ep0_out_stall && ep0_out_toggle));

  // R4
  ack_after_clean_end_chk: assert property (@(posedge clk) disable iff (rst)
    hs_ack |-> $past(dat_end && dat_crc_ok));

  // R4
  data_hold_without_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !hs_ack |-> $stable(setup_data));

  // R1
  no_ack_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(func_en) |-> !hs_ack);

endmodule

bind ep0_setup_capture ep0_setup_capture_chk #(.W(LEN*8)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .func_en        (func_en),
  .dat_end        (dat_end),
  .dat_crc_ok     (dat_crc_ok),
  .hs_ack         (hs_ack),
  .setup_rcvd     (setup_rcvd),
  .setup_data     (setup_data),
  .ep0_in_nak     (ep0_in_nak),
  .ep0_in_stall   (ep0_in_stall),
  .ep0_in_toggle  (ep0_in_toggle),
  .ep0_out_nak    (ep0_out_nak),
  .ep0_out_stall  (ep0_out_stall),
  .ep0_out_toggle (ep0_out_toggle)
);

// File: tb/ep0_setup_capture_tb.sv
`timescale 1ns/1ps
module ep0_setup_capture_tb;

  localparam logic [6:0] OWN = 7'h2A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        func_en = 1'b0;
  logic [6:0]  own_addr = OWN;
  logic        tok_valid = 1'b0, tok_is_setup = 1'b0;
  logic [6:0]  tok_addr = '0;
  logic [3:0]  tok_endp = '0;
  logic        dat_start = 1'b0, dat_pid_data0 = 1'b0;
  logic        dat_byte_valid = 1'b0;
  logic [7:0]  dat_byte = '0;
  logic        dat_end = 1'b0, dat_crc_ok = 1'b0;
  logic        fw_ctl_we_in = 1'b0, fw_ctl_we_out = 1'b0;
  logic [2:0]  fw_ctl_wdata = '0;
  logic        fw_setup_clr = 1'b0;
  logic        hs_ack, setup_rcvd;
  logic [63:0] setup_data;
  logic        ep0_in_nak, ep0_in_stall, ep0_in_toggle;
  logic        ep0_out_nak, ep0_out_stall, ep0_out_toggle;

  always #2 clk = ~clk;

  ep0_setup_capture u_dut (
    .clk(clk), .rst(rst), .func_en(func_en), .own_addr(own_addr),
    .tok_valid(tok_valid), .tok_is_setup(tok_is_setup), .tok_addr(tok_addr),
    .tok_endp(tok_endp), .dat_start(dat_start), .dat_pid_data0(dat_pid_data0),
    .dat_byte_valid(dat_byte_valid), .dat_byte(dat_byte), .dat_end(dat_end),
    .dat_crc_ok(dat_crc_ok), .fw_ctl_we_in(fw_ctl_we_in),
    .fw_ctl_we_out(fw_ctl_we_out), .fw_ctl_wdata(fw_ctl_wdata),
    .fw_setup_clr(fw_setup_clr), .hs_ack(hs_ack), .setup_rcvd(setup_rcvd),
    .setup_data(setup_data), .ep0_in_nak(ep0_in_nak),
    .ep0_in_stall(ep0_in_stall), .ep0_in_toggle(ep0_in_toggle),
    .ep0_out_nak(ep0_out_nak), .ep0_out_stall(ep0_out_stall),
    .ep0_out_toggle(ep0_out_toggle)
  );

  int checks = 0;
  int errors = 0;
  int ack_seen = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_phase = 0;
  logic [7:0]  m_q[$];
  logic [63:0] m_data = '0;
  logic        m_ack = 1'b0, m_rcvd = 1'b0;
  logic [2:0]  m_in = '0, m_out = '0;

  always @(posedge clk) begin
    bit hit;
    bit acc;
    acc = 1'b0;
    if (rst) begin
      m_phase = 0; m_q.delete(); m_data = '0; m_ack = 1'b0; m_rcvd = 1'b0;
      m_in = '0; m_out = '0;
    end else begin
      hit = tok_valid && tok_is_setup && (tok_addr == own_addr) && (tok_endp == 4'd0);
      if (!func_en) begin
        m_phase = 0; m_q.delete();
      end else if (tok_valid) begin
        m_phase = hit ? 1 : 0; m_q.delete();
      end else if (m_phase == 1) begin
        if (dat_start) begin m_phase = dat_pid_data0 ? 2 : 0; m_q.delete(); end
      end else if (m_phase == 2) begin
        if (dat_end) begin
          acc = dat_crc_ok && (m_q.size() == 8);
          m_phase = 0;
        end else if (dat_byte_valid) begin
          m_q.push_back(dat_byte);
        end
      end
      if (acc) for (int k = 0; k < 8; k++) m_data[8*k +: 8] = m_q[k];
      m_ack = acc;
      if (acc) m_rcvd = 1'b1;
      else if (fw_setup_clr) m_rcvd = 1'b0;
      if (acc) begin
        m_in = 3'b101; m_out = 3'b101;
      end else begin
        if (fw_ctl_we_in)  m_in  = fw_ctl_wdata;
        if (fw_ctl_we_out) m_out = fw_ctl_wdata;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (hs_ack === 1'b1) ack_seen++;
      chk("R3 hs_ack", 64'(hs_ack), 64'(m_ack));
      chk("R3 setup_rcvd", 64'(setup_rcvd), 64'(m_rcvd));
      chk("R2 setup_data", setup_data, m_data);
      chk("R5 ep0_in", 64'({ep0_in_nak, ep0_in_stall, ep0_in_toggle}), 64'(m_in));
      chk("R5 ep0_out", 64'({ep0_out_nak, ep0_out_stall, ep0_out_toggle}), 64'(m_out));
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [63:0] pattern(input logic [7:0] base);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = base + 8'(k * 17);
    return v;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_token(input logic is_setup, input logic [6:0] addr, input logic [3:0] ep);
    @(negedge clk);
    tok_valid = 1'b1; tok_is_setup = is_setup; tok_addr = addr; tok_endp = ep;
    @(negedge clk);
    tok_valid = 1'b0; tok_is_setup = 1'b0;
  endtask

  task automatic send_data(input logic d0, input int n, input logic crc,
                           input logic [7:0] base, input bit fw_race);
    dat_start = 1'b1; dat_pid_data0 = d0;
    @(negedge clk);
    dat_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      dat_byte_valid = 1'b1; dat_byte = base + 8'(k * 17);
      @(negedge clk);
    end
    dat_byte_valid = 1'b0;
    dat_end = 1'b1; dat_crc_ok = crc;
    if (fw_race) begin fw_ctl_we_in = 1'b1; fw_ctl_wdata = 3'b010; end
    @(negedge clk);
    dat_end = 1'b0; dat_crc_ok = 1'b0; fw_ctl_we_in = 1'b0;
  endtask

  task automatic fw_write(input bit to_in, input bit to_out, input logic [2:0] v);
    fw_ctl_we_in = to_in; fw_ctl_we_out = to_out; fw_ctl_wdata = v;
    @(negedge clk);
    fw_ctl_we_in = 1'b0; fw_ctl_we_out = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  initial begin
    int a0;
    logic [63:0] held;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 hs_ack", 64'(hs_ack), 64'd0);
    chk("R9 setup_rcvd", 64'(setup_rcvd), 64'd0);
    chk("R9 setup_data", setup_data, 64'd0);
    chk("R9 ctl", 64'({ep0_in_nak, ep0_in_stall, ep0_in_toggle,
                       ep0_out_nak, ep0_out_stall, ep0_out_toggle}), 64'd0);
    func_en = 1'b1;

    // R7: preset NAK+STALL, then a good SETUP must still be acknowledged
    fw_write(1'b1, 1'b0, 3'b110);
    fw_write(1'b0, 1'b1, 3'b010);
    a0 = ack_seen;
    send_token(1'b1, OWN, 4'd0);
    send_data(1'b1, 8, 1'b1, 8'h80, 1'b0);
    idle(1);
    chk("R7 ack despite stall", 64'(ack_seen - a0), 64'd1);
    chk("R2 byte order", setup_data, pattern(8'h80));
    chk("R5 ctl after setup", 64'({ep0_in_nak, ep0_in_stall, ep0_in_toggle,
        ep0_out_nak, ep0_out_stall, ep0_out_toggle}), 64'b101101);

    // R6 firmware clears NAK on IN; R3 clear status
    fw_write(1'b1, 1'b0, 3'b001);
    fw_setup_clr = 1'b1; @(negedge clk); fw_setup_clr = 1'b0;
    chk("R6 fw write in", 64'({ep0_in_nak, ep0_in_stall, ep0_in_toggle}), 64'b001);
    chk("R3 status cleared", 64'(setup_rcvd), 64'd0);

    // R1 mismatches
    held = setup_data;
    a0 = ack_seen;
    send_token(1'b1, OWN + 7'd1, 4'd0); send_data(1'b1, 8, 1'b1, 8'h11, 1'b0);
    send_token(1'b1, OWN, 4'd1);        send_data(1'b1, 8, 1'b1, 8'h22, 1'b0);
    send_token(1'b0, OWN, 4'd0);        send_data(1'b1, 8, 1'b1, 8'h33, 1'b0);
    func_en = 1'b0;
    send_token(1'b1, OWN, 4'd0);        send_data(1'b1, 8, 1'b1, 8'h44, 1'b0);
    func_en = 1'b1;
    idle(2);
    chk("R1 no ack on mismatch", 64'(ack_seen - a0), 64'd0);
    chk("R1 data untouched", setup_data, held);
    chk("R1 status untouched", 64'(setup_rcvd), 64'd0);

    // R4 faulty packets
    a0 = ack_seen;
    send_token(1'b1, OWN, 4'd0); send_data(1'b1, 8, 1'b0, 8'h55, 1'b0);
    send_token(1'b1, OWN, 4'd0); send_data(1'b1, 7, 1'b1, 8'h66, 1'b0);
    send_token(1'b1, OWN, 4'd0); send_data(1'b1, 9, 1'b1, 8'h77, 1'b0);
    send_token(1'b1, OWN, 4'd0); send_data(1'b0, 8, 1'b1, 8'h88, 1'b0);
    idle(2);
    chk("R4 no ack on faulty packet", 64'(ack_seen - a0), 64'd0);
    chk("R4 data untouched", setup_data, held);
    chk("R4 status untouched", 64'(setup_rcvd), 64'd0);

    // R8 new token mid-packet restarts; func_en drop aborts
    a0 = ack_seen;
    send_token(1'b1, OWN, 4'd0);
    dat_start = 1'b1; dat_pid_data0 = 1'b1; @(negedge clk); dat_start = 1'b0;
    for (int k = 0; k < 3; k++) begin dat_byte_valid = 1'b1; dat_byte = 8'hEE; @(negedge clk); end
    dat_byte_valid = 1'b0;
    send_token(1'b1, OWN, 4'd0);
    send_data(1'b1, 8, 1'b1, 8'h10, 1'b0);
    idle(1);
    chk("R8 restart accepted", 64'(ack_seen - a0), 64'd1);
    chk("R8 restart data", setup_data, pattern(8'h10));
    a0 = ack_seen;
    send_token(1'b1, OWN, 4'd0);
    dat_start = 1'b1; dat_pid_data0 = 1'b1; @(negedge clk); dat_start = 1'b0;
    for (int k = 0; k < 8; k++) begin dat_byte_valid = 1'b1; dat_byte = 8'hC0; @(negedge clk); end
    dat_byte_valid = 1'b0; func_en = 1'b0; @(negedge clk);
    func_en = 1'b1; dat_end = 1'b1; dat_crc_ok = 1'b1; @(negedge clk);
    dat_end = 1'b0; dat_crc_ok = 1'b0;
    idle(2);
    chk("R8 abort on disable", 64'(ack_seen - a0), 64'd0);
    chk("R8 data held", setup_data, pattern(8'h10));

    // R6 race: firmware write in the accepting cycle loses
    fw_write(1'b1, 1'b1, 3'b000);
    send_token(1'b1, OWN, 4'd0);
    send_data(1'b1, 8, 1'b1, 8'h3C, 1'b1);
    idle(1);
    chk("R6 setup wins race", 64'({ep0_in_nak, ep0_in_stall, ep0_in_toggle}), 64'b101);
    chk("R2 second request", setup_data, pattern(8'h3C));
    chk("R3 status set", 64'(setup_rcvd), 64'd1);

    idle(4);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule